// File: doc/BRIEF.md
# Interrupt-Triggered Byte Transfer Engine

This block is a single-channel transfer engine. It moves bytes between peripheral registers and on-chip memory over a shared bus, so the CPU does not have to. Each activation source has its own eight-byte descriptor in a table at `CTL_BASE`. The descriptor for source `i` sits at `CTL_BASE + 8*i`. When an enabled source fires, the engine does four things in order. It reads that descriptor over the bus. It copies a block of bytes from the source address to the destination address. It writes the updated descriptor back. On the final transfer it decides whether to raise the source's interrupt to the CPU.

There are two modes. Normal mode finishes when the count runs out: it raises the interrupt and disables the source. Repeat mode reloads the count and rewinds the repeat-area address, then carries on. It forwards the interrupt and stops only when its repeat-interrupt bit is set. A request from a disabled source goes straight to the CPU as an ordinary interrupt. The engine always has priority on the bus, and it signals that the CPU must hold off whenever it is active.

Top module: `irq_xfer_engine`

## Requirements
- R1: A request on a source whose enable bit is 0 produces a one-cycle pulse on that source's `cpuIrq` bit in the next cycle, with no bus access. `enWrite` loads all enable bits from `enData`. All enable bits are 0 after reset.
- R2: A request on an enabled source starts an activation. The engine reads descriptor bytes 0 to 7 at `CTL_BASE + 8*i + k`, in ascending order, before any data move. `cpuHold` is 1 in every cycle that has a bus read or write.
- R3: Descriptor byte layout:
  - Byte 0 is the mode. Bit 0 selects repeat mode. Bit 1 set makes the destination the repeat area (clear makes it the source). Bit 2 makes the source address increment. Bit 3 makes the destination address increment. Bit 4 is the repeat-interrupt enable.
  - Byte 1 is the block length.
  - Byte 2 is the count.
  - Byte 3 is the reload value.
  - Bytes 4 and 5 are the source address, low byte first.
  - Bytes 6 and 7 are the destination address, low byte first.
- R4: An activation moves block-length bytes. Each byte is read from the source address and then written to the destination address. A block length of 0 moves 256 bytes.
- R5: After each byte, the source address advances by one if it increments, and otherwise stays fixed; the same applies to the destination. In repeat mode the repeat-area side always advances.
- R6: At the end of each activation the count drops by one and all eight descriptor bytes are written back. A stored count of 0 means 256, so it becomes 255.
- R7: In normal mode, the activation that takes the count from 1 to 0 ends with a `cpuIrq` pulse for that source. The pulse comes in the first cycle after `cpuHold` falls. The source's enable bit is cleared, so later requests go to the CPU as in R1.
- R8: In repeat mode with bit 4 clear, a count of 1 is reloaded from byte 3 instead of becoming 0. The repeat-area address is rewound by reload times block length. No interrupt is raised, and the source stays enabled.
- R9: In repeat mode with bit 4 set, the reload and rewind of R8 still happen. In addition, the interrupt is raised and the enable bit is cleared, as in R7.
- R10: When several requests are pending, the lowest-numbered source is served first. A request that arrives during an activation is held and served afterwards. The exception is a held request for a source that is stopped by R7 or R9: that request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| actReq | input | NUM_SRC | Activation request pulses, one per source |
| enWrite | input | 1 | Load strobe for the enable bits |
| enData | input | NUM_SRC | New enable bits |
| memAddr | output | 16 | Bus address |
| memRe | output | 1 | Bus read; data returns on memRdata one cycle later |
| memWe | output | 1 | Bus write |
| memWdata | output | 8 | Bus write data |
| memRdata | input | 8 | Bus read data |
| cpuHold | output | 1 | Engine owns the bus; the CPU must wait |
| cpuIrq | output | NUM_SRC | Interrupt pulses forwarded to the CPU |

## Verification
Two events can fall in the same cycle. The first is a source's final normal-mode activation, which stops the source. The second is a new request from that same source, already latched as pending. The bench provokes this by firing the same source again while its last activation is still on the bus. It expects exactly one interrupt pulse, and no further bus activity after the engine goes idle. A second test fires two enabled sources in one cycle. It judges the result by the order in which their descriptors are fetched.

// File: rtl/ixe_pkg.sv
package ixe_pkg;
  localparam int ADDR_W = 16;
  localparam int DESC_BYTES = 8;

  localparam int MB_REPEAT = 0;
  localparam int MB_RPT_DST = 1;
  localparam int MB_SRC_INC = 2;
  localparam int MB_DST_INC = 3;
  localparam int MB_RPT_IRQ = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CTL_RD, ST_CTL_CAP, ST_SRC_RD, ST_DST_WR, ST_WB, ST_DONE
  } ixe_state_e;

  typedef struct packed {
    logic       ctlRead;
    logic       ctlCapture;
    logic       srcRead;
    logic       dstWrite;
    logic       wbWrite;
    logic [2:0] byteSel;
  } ixe_strobe_t;
endpackage

// File: rtl/ixe_ctrl.sv
module ixe_ctrl
  import ixe_pkg::*;
#(
  parameter int NUM_SRC = 23,
  parameter logic [ADDR_W-1:0] CTL_BASE = 16'h0E00
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SRC-1:0]  actReq,
  input  logic                enWrite,
  input  logic [NUM_SRC-1:0]  enData,
  input  logic                blockDone,
  input  logic                isFinal,
  input  logic                isRepeat,
  input  logic                rptIrq,
  output ixe_strobe_t         strb,
  output logic [ADDR_W-1:0]   ctlAddr,
  output logic                busy,
  output logic [NUM_SRC-1:0]  cpuIrq
);
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  ixe_state_e         state;
  logic [2:0]         byteIdx;
  logic [SEL_W-1:0]   selIdx;
  logic [NUM_SRC-1:0] enReg, pendReg, irqReg;

  logic [SEL_W-1:0]   pick;
  logic               hit;
  always_comb begin
    pick = '0;
    hit  = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendReg[i]) begin
        pick = SEL_W'(i);
        hit  = 1'b1;
      end
    end
  end

  logic               stopNow;
  logic [NUM_SRC-1:0] selMask, pickMask, clrMask, stopMask;
  assign stopNow  = (state == ST_DONE) && isFinal && (!isRepeat || rptIrq);
  assign selMask  = NUM_SRC'(1) << selIdx;
  assign pickMask = NUM_SRC'(1) << pick;
  assign stopMask = stopNow ? selMask : '0;
  assign clrMask  = ((state == ST_IDLE && hit) ? pickMask : '0) | stopMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      byteIdx <= '0;
      selIdx  <= '0;
      enReg   <= '0;
      pendReg <= '0;
      irqReg  <= '0;
    end else begin
      enReg   <= (enWrite ? enData : enReg) & ~stopMask;
      pendReg <= (pendReg | (actReq & enReg)) & ~clrMask;
      irqReg  <= (actReq & ~enReg) | stopMask;
      unique case (state)
        ST_IDLE: if (hit) begin
          selIdx  <= pick;
          byteIdx <= '0;
          state   <= ST_CTL_RD;
        end
        ST_CTL_RD: state <= ST_CTL_CAP;
        ST_CTL_CAP: begin
          byteIdx <= byteIdx + 3'd1;
          state   <= (byteIdx == 3'd7) ? ST_SRC_RD : ST_CTL_RD;
        end
        ST_SRC_RD: state <= ST_DST_WR;
        ST_DST_WR: begin
          byteIdx <= '0;
          state   <= blockDone ? ST_WB : ST_SRC_RD;
        end
        ST_WB: begin
          byteIdx <= byteIdx + 3'd1;
          if (byteIdx == 3'd7) state <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb            = '0;
    strb.ctlRead    = (state == ST_CTL_RD);
    strb.ctlCapture = (state == ST_CTL_CAP);
    strb.srcRead    = (state == ST_SRC_RD);
    strb.dstWrite   = (state == ST_DST_WR);
    strb.wbWrite    = (state == ST_WB);
    strb.byteSel    = byteIdx;
  end

  assign ctlAddr = CTL_BASE + ADDR_W'({selIdx, byteIdx});
  assign busy    = (state != ST_IDLE);
  assign cpuIrq  = irqReg;
endmodule

// File: rtl/ixe_dp.sv
module ixe_dp
  import ixe_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ixe_strobe_t       strb,
  input  logic [ADDR_W-1:0] ctlAddr,
  input  logic [7:0]        memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [7:0]        memWdata,
  output logic              blockDone,
  output logic              isFinal,
  output logic              isRepeat,
  output logic              rptIrq
);
  logic [4:0]        modeR;
  logic [7:0]        blkR, cntR, rldR;
  logic [ADDR_W-1:0] srcR, dstR;
  logic [8:0]        leftR;
  logic              finalR;

  logic              rep, rptDst, srcStep, dstStep, lastCount;
  logic [8:0]        blkLen;
  logic [ADDR_W-1:0] rewind, srcNx, dstNx;

  assign rep       = modeR[MB_REPEAT];
  assign rptDst    = modeR[MB_RPT_DST];
  assign srcStep   = modeR[MB_SRC_INC] | (rep & ~rptDst);
  assign dstStep   = modeR[MB_DST_INC] | (rep & rptDst);
  assign lastCount = (cntR == 8'd1);
  assign blkLen    = (blkR == 8'd0) ? 9'd256 : {1'b0, blkR};
  assign rewind    = {8'b0, rldR} * {7'b0, blkLen};
  assign srcNx     = srcR + ADDR_W'(srcStep);
  assign dstNx     = dstR + ADDR_W'(dstStep);
  assign blockDone = (leftR == 9'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeR <= '0; blkR <= '0; cntR <= '0; rldR <= '0;
      srcR <= '0; dstR <= '0; leftR <= '0; finalR <= 1'b0;
    end else if (strb.ctlCapture) begin
      unique case (strb.byteSel)
        3'd0: begin modeR <= memRdata[4:0]; finalR <= 1'b0; end
        3'd1: begin
          blkR  <= memRdata;
          leftR <= (memRdata == 8'd0) ? 9'd256 : {1'b0, memRdata};
        end
        3'd2: cntR <= memRdata;
        3'd3: rldR <= memRdata;
        3'd4: srcR[7:0]  <= memRdata;
        3'd5: srcR[15:8] <= memRdata;
        3'd6: dstR[7:0]  <= memRdata;
        default: dstR[15:8] <= memRdata;
      endcase
    end else if (strb.dstWrite) begin
      leftR <= leftR - 9'd1;
      srcR  <= srcNx;
      dstR  <= dstNx;
      if (blockDone) begin
        finalR <= lastCount;
        if (rep && lastCount) begin
          cntR <= rldR;
          if (rptDst) dstR <= dstNx - rewind;
          else        srcR <= srcNx - rewind;
        end else begin
          cntR <= cntR - 8'd1;
        end
      end
    end
  end

  assign memRe = strb.ctlRead | strb.srcRead;
  assign memWe = strb.dstWrite | strb.wbWrite;

  always_comb begin
    if (strb.ctlRead || strb.wbWrite) memAddr = ctlAddr;
    else if (strb.srcRead)            memAddr = srcR;
    else                              memAddr = dstR;
  end

  always_comb begin
    if (strb.dstWrite) memWdata = memRdata;
    else begin
      unique case (strb.byteSel)
        3'd0: memWdata = {3'b0, modeR};
        3'd1: memWdata = blkR;
        3'd2: memWdata = cntR;
        3'd3: memWdata = rldR;
        3'd4: memWdata = srcR[7:0];
        3'd5: memWdata = srcR[15:8];
        3'd6: memWdata = dstR[7:0];
        default: memWdata = dstR[15:8];
      endcase
    end
  end

  assign isFinal  = finalR;
  assign isRepeat = rep;
  assign rptIrq   = modeR[MB_RPT_IRQ];
endmodule

// File: rtl/irq_xfer_engine.sv
module irq_xfer_engine
  import ixe_pkg::*;
#(
  parameter int NUM_SRC = 23,
  parameter logic [ADDR_W-1:0] CTL_BASE = 16'h0E00
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SRC-1:0]  actReq,
  input  logic                enWrite,
  input  logic [NUM_SRC-1:0]  enData,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memRe,
  output logic                memWe,
  output logic [7:0]          memWdata,
  input  logic [7:0]          memRdata,
  output logic                cpuHold,
  output logic [NUM_SRC-1:0]  cpuIrq
);
  ixe_strobe_t       strb;
  logic [ADDR_W-1:0] ctlAddr;
  logic              blockDone, isFinal, isRepeat, rptIrq;

  ixe_ctrl #(.NUM_SRC(NUM_SRC), .CTL_BASE(CTL_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .actReq(actReq), .enWrite(enWrite), .enData(enData),
    .blockDone(blockDone), .isFinal(isFinal), .isRepeat(isRepeat), .rptIrq(rptIrq),
    .strb(strb), .ctlAddr(ctlAddr), .busy(cpuHold), .cpuIrq(cpuIrq)
  );

  ixe_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ctlAddr(ctlAddr), .memRdata(memRdata),
    .memAddr(memAddr), .memRe(memRe), .memWe(memWe), .memWdata(memWdata),
    .blockDone(blockDone), .isFinal(isFinal), .isRepeat(isRepeat), .rptIrq(rptIrq)
  );
endmodule

// File: rtl/ixe_checker.sv
module ixe_checker
  import ixe_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        memRe,
  input logic        memWe,
  input logic        cpuHold,
  input ixe_strobe_t strb
);
  assert_bus_owned_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memRe || memWe) |-> cpuHold);

  assert_desc_pair_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.ctlCapture |-> $past(strb.ctlRead));

  assert_start_fetch_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuHold) |-> (memRe && !memWe));

  assert_read_before_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.dstWrite |-> $past(strb.srcRead));

  assert_wb_after_block_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wbWrite && strb.byteSel == 3'd0) |-> $past(strb.dstWrite));
endmodule

bind irq_xfer_engine ixe_checker u_chk (
  .clk(clk), .rstN(rstN), .memRe(memRe), .memWe(memWe),
  .cpuHold(cpuHold), .strb(strb)
);

// File: tb/irq_xfer_engine_bench.sv
module irq_xfer_engine_bench;
  localparam int NSRC = 23;
  localparam logic [15:0] BASE = 16'h0E00;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NSRC-1:0] actReq = '0;
  logic enWrite = 1'b0;
  logic [NSRC-1:0] enData = '0;
  logic [15:0] memAddr;
  logic memRe, memWe, cpuHold;
  logic [7:0] memWdata;
  logic [7:0] memRdata = 8'h00;
  logic [NSRC-1:0] cpuIrq;

  always #2 clk = ~clk;

  irq_xfer_engine #(.NUM_SRC(NSRC), .CTL_BASE(BASE)) u_irq_xfer_engine (
    .clk(clk), .rstN(rstN), .actReq(actReq), .enWrite(enWrite), .enData(enData),
    .memAddr(memAddr), .memRe(memRe), .memWe(memWe), .memWdata(memWdata),
    .memRdata(memRdata), .cpuHold(cpuHold), .cpuIrq(cpuIrq)
  );

  logic [7:0] mem [0:4095];
  logic tbWe = 1'b0;
  logic [11:0] tbAddr = '0;
  logic [7:0] tbData = '0;
  always @(posedge clk) begin
    if (tbWe) mem[tbAddr] <= tbData;
    else if (memWe) mem[memAddr[11:0]] <= memWdata;
    if (memRe) memRdata <= mem[memAddr[11:0]];
  end

  int errors = 0;
  int checks = 0;
  int irqCnt [NSRC];
  logic holdSeen = 1'b0;
  int order [8];
  int nOrder = 0;
  bit finished = 0;

  always @(posedge clk) begin
    for (int i = 0; i < NSRC; i++) if (cpuIrq[i]) irqCnt[i]++;
    if (cpuHold) holdSeen <= 1'b1;
    if (memRe && memAddr >= BASE && memAddr[2:0] == 3'd0 && nOrder < 8) begin
      order[nOrder] = int'((memAddr - BASE) >> 3);
      nOrder++;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input int a, input int v);
    @(negedge clk);
    tbWe = 1'b1; tbAddr = 12'(a); tbData = 8'(v);
    @(negedge clk);
    tbWe = 1'b0;
  endtask

  function automatic int peek16(input int a);
    return {mem[12'(a + 1)], mem[12'(a)]};
  endfunction

  task automatic setDesc(input int idx, input int mode, input int blk, input int cnt,
                         input int rld, input int src, input int dst);
    int b;
    b = int'(BASE) + idx * 8;
    poke(b, mode); poke(b + 1, blk); poke(b + 2, cnt); poke(b + 3, rld);
    poke(b + 4, src & 255); poke(b + 5, src >> 8);
    poke(b + 6, dst & 255); poke(b + 7, dst >> 8);
  endtask

  task automatic setEn(input logic [NSRC-1:0] m);
    @(negedge clk); enWrite = 1'b1; enData = m;
    @(negedge clk); enWrite = 1'b0;
  endtask

  task automatic fire(input logic [NSRC-1:0] m);
    @(negedge clk); actReq = m;
    @(negedge clk); actReq = '0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (!cpuHold && n < 40) begin @(negedge clk); n++; end
    while (cpuHold && n < 5000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 reset hold", int'(cpuHold), 0);
    check("R1 reset irq", int'(cpuIrq), 0);
    check("R2 reset bus", int'(memRe | memWe), 0);
  endtask

  task automatic t_disabled();
    int c;
    c = irqCnt[2];
    holdSeen = 1'b0;
    fire(NSRC'(1) << 2);
    repeat (6) @(negedge clk);
    check("R1 disabled irq", irqCnt[2] - c, 1);
    check("R1 disabled no bus", int'(holdSeen), 0);
  endtask

  task automatic t_normalSingle();
    int c;
    poke(12'h100, 8'hA5); poke(12'h101, 8'h3C);
    setDesc(0, 8'h04, 1, 3, 0, 16'h0100, 16'h0200);
    setEn(NSRC'(1));
    c = irqCnt[0];
    nOrder = 0;
    fire(NSRC'(1)); waitIdle();
    check("R2 desc fetch index", order[0], 0);
    check("R4 byte copied", int'(mem[12'h200]), 8'hA5);
    check("R6 count written back", int'(mem[12'(BASE + 2)]), 2);
    check("R5 src incremented", peek16(int'(BASE) + 4), 16'h0101);
    check("R5 dst fixed", peek16(int'(BASE) + 6), 16'h0200);
    check("R3 mode written back", int'(mem[12'(BASE)]), 8'h04);
    fire(NSRC'(1)); waitIdle();
    check("R5 second byte to fixed dst", int'(mem[12'h200]), 8'h3C);
    check("R7 no irq before final", irqCnt[0] - c, 0);
  endtask

  task automatic t_blockFinal();
    int c;
    for (int i = 0; i < 4; i++) poke(12'h300 + i, 8'h10 + i);
    setDesc(1, 8'h0C, 4, 1, 0, 16'h0300, 16'h0400);
    setEn(NSRC'(1) << 1);
    c = irqCnt[1];
    fire(NSRC'(1) << 1); waitIdle();
    for (int i = 0; i < 4; i++) check("R4 block byte", int'(mem[12'h400 + i]), 8'h10 + i);
    check("R6 count reaches zero", int'(mem[12'(BASE + 10)]), 0);
    check("R5 src after block", peek16(int'(BASE) + 12), 16'h0304);
    check("R5 dst after block", peek16(int'(BASE) + 14), 16'h0404);
    check("R7 final irq", irqCnt[1] - c, 1);
    holdSeen = 1'b0;
    fire(NSRC'(1) << 1);
    repeat (6) @(negedge clk);
    check("R7 enable cleared no bus", int'(holdSeen), 0);
    check("R7 later request to cpu", irqCnt[1] - c, 2);
  endtask

  task automatic t_block256();
    for (int i = 0; i < 256; i++) poke(12'h500 + i, i ^ 8'h5A);
    setDesc(3, 8'h0C, 0, 0, 0, 16'h0500, 16'h0700);
    setEn(NSRC'(1) << 3);
    fire(NSRC'(1) << 3); waitIdle();
    check("R4 256 first", int'(mem[12'h700]), 8'h5A);
    check("R4 256 last", int'(mem[12'h7FF]), 8'hFF ^ 8'h5A);
    check("R4 256 src end", peek16(int'(BASE) + 28), 16'h0600);
    check("R6 count 0 means 256", int'(mem[12'(BASE + 26)]), 255);
  endtask

  task automatic t_repeat();
    int c;
    for (int i = 0; i < 6; i++) poke(12'h900 + i, 8'hC0 + i);
    setDesc(4, 8'h07, 2, 2, 2, 16'h0900, 16'h0A00);
    setEn(NSRC'(1) << 4);
    c = irqCnt[4];
    fire(NSRC'(1) << 4); waitIdle();
    check("R6 repeat count step", int'(mem[12'(BASE + 34)]), 1);
    fire(NSRC'(1) << 4); waitIdle();
    check("R8 count reloaded", int'(mem[12'(BASE + 34)]), 2);
    check("R8 dst rewound", peek16(int'(BASE) + 38), 16'h0A00);
    check("R8 src keeps going", peek16(int'(BASE) + 36), 16'h0904);
    check("R8 no irq", irqCnt[4] - c, 0);
    fire(NSRC'(1) << 4); waitIdle();
    check("R8 continues after rewind", int'(mem[12'hA00]), 8'hC4);
    check("R8 continues second byte", int'(mem[12'hA01]), 8'hC5);
  endtask

  task automatic t_repeatIrq();
    int c;
    poke(12'hB00, 8'h77);
    setDesc(5, 8'h11, 1, 1, 3, 16'h0B00, 16'h0B80);
    setEn(NSRC'(1) << 5);
    c = irqCnt[5];
    fire(NSRC'(1) << 5); waitIdle();
    check("R9 byte moved", int'(mem[12'hB80]), 8'h77);
    check("R9 src rewound", peek16(int'(BASE) + 44), 16'h0AFE);
    check("R9 count reloaded", int'(mem[12'(BASE + 42)]), 3);
    check("R9 irq", irqCnt[5] - c, 1);
    holdSeen = 1'b0;
    fire(NSRC'(1) << 5);
    repeat (6) @(negedge clk);
    check("R9 stopped no bus", int'(holdSeen), 0);
  endtask

  task automatic t_priority();
    poke(12'hC80, 8'h61); poke(12'hC90, 8'h62);
    setDesc(7, 8'h00, 1, 5, 0, 16'h0C90, 16'h0CA0);
    setDesc(6, 8'h00, 1, 5, 0, 16'h0C80, 16'h0CB0);
    setEn((NSRC'(1) << 6) | (NSRC'(1) << 7));
    nOrder = 0;
    fire((NSRC'(1) << 6) | (NSRC'(1) << 7));
    waitIdle(); waitIdle();
    check("R10 lower first", order[0], 6);
    check("R10 higher second", order[1], 7);
    check("R10 both served", int'(mem[12'hCA0]), 8'h62);
  endtask

  task automatic t_sameCycle();
    int c;
    poke(12'hC00, 8'h21); poke(12'hC01, 8'h22);
    setDesc(8, 8'h0C, 2, 1, 0, 16'h0C00, 16'h0C40);
    setEn(NSRC'(1) << 8);
    c = irqCnt[8];
    fire(NSRC'(1) << 8);
    while (!cpuHold) @(negedge clk);
    repeat (3) @(negedge clk);
    @(negedge clk); actReq = NSRC'(1) << 8;
    @(negedge clk); actReq = '0;
    while (cpuHold) @(negedge clk);
    repeat (2) @(negedge clk);
    holdSeen = 1'b0;
    repeat (10) @(negedge clk);
    check("R10 dropped request no bus", int'(holdSeen), 0);
    check("R7 single irq", irqCnt[8] - c, 1);
    check("R4 overlap block copied", int'(mem[12'hC41]), 8'h22);
  endtask

  initial begin
    for (int i = 0; i < NSRC; i++) irqCnt[i] = 0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_disabled();
    t_normalSingle();
    t_blockFinal();
    t_block256();
    t_repeat();
    t_repeatIrq();
    t_priority();
    t_sameCycle();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule